// File: doc/BRIEF.md
# Dual-Select Static Memory Model

This block is a clock-sampled, synthesizable stand-in for a byte-wide asynchronous static memory. Its purpose is to serve as a test target for memory controllers. It has a 16-bit address, an 8-bit data path and four control pins: an active-low select, an active-high select, an active-low output enable and an active-low write enable. The block samples every pin on each rising clock edge. The device is selected only when both selects are asserted.

A write window is open while both selects and the write enable are asserted. The window therefore opens on whichever of the three becomes asserted last, and it closes on whichever is released first. The store takes place at the first edge that sees the window closed. It uses the address and data sampled at the last edge that saw the window open. Write enable takes precedence over output enable.

A read drives the stored byte on `rd_data` together with `rd_valid`, a flag that replaces a three-state bus. The flag rises a programmable number of edges after read mode begins or the address moves, and `rd_data` is zero whenever the flag is low. The storage keeps 2^`STORE_AW` bytes. Upper address bits above that range alias, and `STORE_AW` = 16 gives the full 64K x 8 organisation. Contents are undefined after reset.

Top module: `dsel_sram_model`

## Requirements
- R1: While `rst_n` is low and on the first edges after it, `rd_valid` is 0 and `rd_data` is 0.
- R2: At any edge that samples `sel_n` high, no read starts, `rd_valid` is 0 after that edge, and no write window is open.
- R3: At any edge that samples `sel_p` low, no read starts, `rd_valid` is 0 after that edge, and no write window is open.
- R4: With both selects asserted and both `oe_n` and `wr_n` high, `rd_valid` stays 0.
- R5: Read mode means `sel_n`=0, `sel_p`=1, `oe_n`=0 and `wr_n`=1. After `RD_LAT` consecutive edges that sample read mode at the same address, `rd_valid` is 1 and `rd_data` equals the last byte stored at that address. After fewer such edges, `rd_valid` is 0.
- R6: An address change during read mode restarts the latency count. The edge that samples the new address counts as the first of the `RD_LAT` edges.
- R7: `rd_valid` is 0 after the first edge that does not sample read mode.
- R8: With both selects asserted and `wr_n` low, `rd_valid` is 0 whatever the value of `oe_n`, and the window writes.
- R9: A store happens at the first edge that samples the window closed. It writes the `wr_data` and `addr` that were sampled at the last edge the window was open. Values that are present only at the closing edge are ignored.
- R10: The window closes when any one of three events occurs: `sel_n` rising, `sel_p` falling or `wr_n` rising. It opens only when all three are asserted together.
- R11: A stored byte at address A is readable at any address that equals A modulo 2^`STORE_AW`.
- R12: `rd_data` is 0 at every edge where `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| sel_p | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (16) | Byte address |
| wr_data | input | DATA_W (8) | Data into the memory |
| rd_data | output | DATA_W (8) | Read data, zero when not valid |
| rd_valid | output | 1 | Read data is being driven |

## Verification
The bench closes write windows through each of the three controls in turn. A design that only watched `wr_n` would lose bytes that are ended by a select. It also changes the data and address on the closing edge itself, so a design that latched at the closing edge would store the wrong byte or store it at the wrong address. Holding `wr_n` low while one select is released must leave a previously written byte intact. A bug of that kind would show up as corruption on a later read. Address moves during a read, `oe_n` low during a write, and an aliased address expose a latency counter that fails to restart, a read that leaks through a write, and a wrong index slice.

// File: rtl/dsel_pkg.sv
package dsel_pkg;
  // Both selects asserted: active-low one low, active-high one high.
  function automatic logic is_selected(input logic sel_n, input logic sel_p);
    return !sel_n && sel_p;
  endfunction

  // Write window: device selected and write enable asserted.
  function automatic logic in_write(input logic sel_n, input logic sel_p,
                                    input logic wr_n);
    return is_selected(sel_n, sel_p) && !wr_n;
  endfunction

  // Read mode: selected, output enabled, write enable released.
  function automatic logic in_read(input logic sel_n, input logic sel_p,
                                   input logic oe_n, input logic wr_n);
    return is_selected(sel_n, sel_p) && !oe_n && wr_n;
  endfunction

  // Saturating step toward a limit.
  function automatic int unsigned sat_step(input int unsigned v,
                                           input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/dsel_write_ctl.sv
module dsel_write_ctl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_open,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  logic win_q;

  // A store fires at the first edge that sees the window shut.
  assign commit = win_q && !wr_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      win_q <= wr_open;
      if (wr_open) begin
        cap_addr <= addr;
        cap_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/dsel_store.sv
module dsel_store #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int STORE_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << STORE_AW;

  logic [DATA_W-1:0]   mem [DEPTH];
  logic [STORE_AW-1:0] widx;
  logic [STORE_AW-1:0] ridx;

  assign widx = waddr[STORE_AW-1:0];
  assign ridx = raddr[STORE_AW-1:0];

  generate
    if (STORE_AW < ADDR_W) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^{waddr[ADDR_W-1:STORE_AW], raddr[ADDR_W-1:STORE_AW]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  // Registered read with same-edge bypass of a store.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (we && widx == ridx) rdata <= wdata;
    else rdata <= mem[ridx];
  end
endmodule

// File: rtl/dsel_read_ctl.sv
module dsel_read_ctl #(
  parameter int ADDR_W = 16,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_open,
  input  logic [ADDR_W-1:0] addr,
  output logic              restart,
  output logic              valid
);
  import dsel_pkg::*;

  localparam int CW = $clog2(RD_LAT + 1);

  logic              rd_prev;
  logic [ADDR_W-1:0] addr_prev;
  logic [CW-1:0]     run;

  assign restart = rd_open && (!rd_prev || addr != addr_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev   <= 1'b0;
      addr_prev <= '0;
      run       <= '0;
    end else begin
      rd_prev   <= rd_open;
      addr_prev <= addr;
      if (!rd_open)     run <= '0;
      else if (restart) run <= CW'(1);
      else              run <= CW'(sat_step(32'(run), RD_LAT));
    end
  end

  assign valid = (run >= CW'(RD_LAT));
endmodule

// File: rtl/dsel_sram_model.sv
module dsel_sram_model #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int STORE_AW = 10,
  parameter int RD_LAT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel_p,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import dsel_pkg::*;

  logic              wr_open;
  logic              rd_open;
  logic              commit;
  logic              restart;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] mem_q;

  assign wr_open = in_write(sel_n, sel_p, wr_n);
  assign rd_open = in_read(sel_n, sel_p, oe_n, wr_n);

  dsel_write_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_open(wr_open), .addr(addr),
    .wr_data(wr_data), .commit(commit), .cap_addr(cap_addr),
    .cap_data(cap_data)
  );

  dsel_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_AW(STORE_AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(commit), .waddr(cap_addr),
    .wdata(cap_data), .raddr(addr), .rdata(mem_q)
  );

  dsel_read_ctl #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_open(rd_open), .addr(addr),
    .restart(restart), .valid(rd_valid)
  );

  assign rd_data = rd_valid ? mem_q : '0;
endmodule

// File: rtl/dsel_sram_chk.sv
module dsel_sram_chk #(
  parameter int ADDR_W = 16,
  parameter int RD_LAT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              sel_p,
  input logic              oe_n,
  input logic              wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_valid,
  input logic              commit,
  input logic              restart
);
  p_desel_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !rd_valid);

  p_desel_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_p |=> !rd_valid);

  p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !rd_valid);

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> !rd_valid);

  p_rise_from_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(!sel_n && sel_p && !oe_n && wr_n));

  p_stable_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (RD_LAT >= 2 && rd_valid) |-> ($past(addr) == $past(addr, 2)));

  p_restart_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (RD_LAT >= 2 && restart) |=> !rd_valid);

  p_commit_on_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (sel_n || !sel_p || wr_n));
endmodule

bind dsel_sram_model dsel_sram_chk #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_p(sel_p), .oe_n(oe_n),
  .wr_n(wr_n), .addr(addr), .rd_valid(rd_valid), .commit(commit),
  .restart(restart)
);

// File: tb/test_dsel_sram_model.sv
`timescale 1ns/1ps
module test_dsel_sram_model;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int SAW = 10;
  localparam int LAT = 2;
  localparam int MASK = (1 << SAW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sel_p = 1'b0, oe_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dsel_sram_model #(.ADDR_W(AW), .DATA_W(DW), .STORE_AW(SAW), .RD_LAT(LAT))
    i_dsel_sram_model (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_p(sel_p), .oe_n(oe_n),
      .wr_n(wr_n), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .rd_valid(rd_valid));

  // Behavioural reference: sparse store, open-window flag, run length.
  logic [7:0] ref_mem [int];
  bit ref_win = 0, ref_rdprev = 0, ref_valid = 0;
  int ref_caddr = 0, ref_cdata = 0, ref_run = 0, ref_aprev = 0, ref_raddr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_win = 0; ref_rdprev = 0; ref_run = 0; ref_valid = 0;
    end else begin
      bit sel, wr_now, rd_now;
      sel    = (sel_n == 1'b0) && (sel_p == 1'b1);
      wr_now = sel && (wr_n == 1'b0);
      rd_now = sel && (oe_n == 1'b0) && (wr_n == 1'b1);
      if (ref_win && !wr_now) ref_mem[ref_caddr] = ref_cdata[7:0];
      if (wr_now) begin ref_caddr = int'(addr) & MASK; ref_cdata = int'(wr_data); end
      ref_win = wr_now;
      if (!rd_now) ref_run = 0;
      else if (!ref_rdprev || int'(addr) != ref_aprev) ref_run = 1;
      else if (ref_run < LAT) ref_run++;
      ref_rdprev = rd_now;
      ref_aprev  = int'(addr);
      ref_raddr  = int'(addr) & MASK;
      ref_valid  = (ref_run >= LAT);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the reference on every clock, away from the edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5/R7 valid vs model", int'(rd_valid), int'(ref_valid));
      if (!ref_valid) chk("R12 data zero when idle", int'(rd_data), 0);
      else if (ref_mem.exists(ref_raddr))
        chk("R5 data vs model", int'(rd_data), int'(ref_mem[ref_raddr]));
    end
  end

  task automatic drive(input logic s_n, input logic s_p, input logic o_n,
                       input logic w_n, input int a, input int d);
    #1;
    sel_n = s_n; sel_p = s_p; oe_n = o_n; wr_n = w_n;
    addr = AW'(a); wr_data = DW'(d);
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic idle(); drive(1, 0, 1, 1, 0, 0); tick(); endtask

  task automatic wr_byte(input int a, input int d);
    drive(0, 1, 1, 0, a, d); tick();
    drive(0, 1, 1, 1, a, d); tick();
  endtask

  task automatic rd_expect(input string tag, input int a, input int d);
    drive(0, 1, 0, 1, a, 0);
    for (int i = 1; i < LAT; i++) begin
      tick(); chk({tag, " not yet valid"}, int'(rd_valid), 0);
    end
    tick();
    chk({tag, " valid"}, int'(rd_valid), 1);
    chk({tag, " data"}, int'(rd_data), d);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_up();
  end

  initial begin
    repeat (3) tick();
    chk("R1 valid in reset", int'(rd_valid), 0);
    chk("R1 data in reset", int'(rd_data), 0);
    drive(1, 0, 1, 1, 0, 0); rst_n = 1'b1;
    tick(); tick();
    chk("R1 valid after reset", int'(rd_valid), 0);

    // R5: basic store and read
    wr_byte(16'h0123, 8'hA5);
    rd_expect("R5 read 0x0123", 16'h0123, 8'hA5);
    idle();

    // R9: data/address moved on the closing edge are ignored
    drive(0, 1, 1, 0, 16'h0040, 8'h11); tick();
    drive(0, 1, 1, 0, 16'h0040, 8'h22); tick();
    drive(0, 1, 1, 1, 16'h0041, 8'h33); tick();
    rd_expect("R9 last-open data kept", 16'h0040, 8'h22);
    idle();

    // R10: close by active-low select rising, then by active-high falling
    drive(0, 1, 1, 0, 16'h0050, 8'h5A); tick();
    drive(1, 1, 1, 0, 16'h0050, 8'h00); tick();
    drive(0, 1, 1, 0, 16'h0051, 8'h6B); tick();
    drive(0, 0, 1, 0, 16'h0051, 8'h00); tick();
    idle();
    rd_expect("R10 close by sel_n", 16'h0050, 8'h5A);
    rd_expect("R10 close by sel_p", 16'h0051, 8'h6B);
    idle();

    // R2/R3: write enable low while deselected must not store
    wr_byte(16'h0061, 8'h44);
    drive(0, 0, 1, 0, 16'h0061, 8'h99); tick();
    drive(1, 1, 1, 0, 16'h0061, 8'h98); tick();
    drive(1, 0, 1, 1, 16'h0061, 8'h97); tick();
    rd_expect("R2 R3 deselected write ignored", 16'h0061, 8'h44);
    drive(1, 1, 0, 1, 16'h0061, 0); tick();
    chk("R2 sel_n high blocks read", int'(rd_valid), 0);
    chk("R12 idle data", int'(rd_data), 0);
    drive(0, 0, 0, 1, 16'h0061, 0); tick();
    chk("R3 sel_p low blocks read", int'(rd_valid), 0);

    // R4: selected, outputs disabled
    drive(0, 1, 1, 1, 16'h0061, 0);
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R4 outputs disabled", int'(rd_valid), 0);
    end

    // R8: write enable overrides output enable, and stores
    drive(0, 1, 0, 0, 16'h0070, 8'hE1);
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R8 no read during write", int'(rd_valid), 0);
    end
    rd_expect("R8 write with oe low stored", 16'h0070, 8'hE1);

    // R6: address move restarts the latency
    drive(0, 1, 0, 1, 16'h0040, 0); tick();
    chk("R6 valid drops on move", int'(rd_valid), 0);
    tick();
    chk("R6 valid back", int'(rd_valid), 1);
    chk("R6 new data", int'(rd_data), 8'h22);

    // R7: leaving read mode drops the flag after one edge
    drive(0, 1, 1, 1, 16'h0040, 0); tick();
    chk("R7 valid falls", int'(rd_valid), 0);
    chk("R12 data zero after read", int'(rd_data), 0);

    // R11: aliasing above the stored range
    wr_byte(16'h0405, 8'hC3);
    rd_expect("R11 alias read", 16'h0005, 8'hC3);
    idle();

    // Mixed traffic, checked against the reference each clock
    for (int i = 0; i < 40; i++) begin
      wr_byte((i * 37) & 16'hFFFF, (i * 11 + 3) & 8'hFF);
      rd_expect("R5 sweep", (i * 37) & 16'hFFFF, (i * 11 + 3) & 8'hFF);
    end
    idle();
    finish_up();
  end
endmodule